// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

This block sits between a framebuffer fetch engine and a display pipe. It takes 32-bit words from the fetch side on a valid/ready handshake, splits each word into pixels according to a 3-bit depth code, and emits one 24-bit RGB pixel per accepted transfer on a second valid/ready stream. Indexed depths (1, 2, 4 and 8 bits per pixel) place an 8-bit index on a palette lookup port and forward the colour that the external palette returns in the same cycle. Direct-colour depths (16-bit 5551 or 565, 12-bit 4:4:4 and a 32-bit word per pixel) are widened to 8 bits per component here.

Two ordering bits choose where pixel 0 sits inside a word. A red/blue swap bit chooses which end of a direct-colour field is red. A 2-bit external select changes how depth code 4 is read, and in one of its settings the swap bit is overridden. Pixels flow only while both the enable and the power input are high. From a column count the block also reports how many bytes one display line takes in memory, which the fetch engine uses to step through the buffer.

Top module: `fb_pixel_unpack`

## Requirements
- R1: Depth codes map as 0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=16 bpp (select-dependent), 5=32 bits per pixel, 6=16 bpp 565, 7=12 bpp; a word yields 32/bpp pixels, and with both ordering bits low pixel k is taken from bits [k*bpp +: bpp].
- R2: `line_bytes` equals cols/8, cols/4, cols/2, cols, cols*2, cols*4, cols*2, cols*2 for depth codes 0 to 7 respectively (division truncating).
- R3: With `cfg_be_byte` high, pixel 0 is taken from the most significant end (pixel k from bits [32-(k+1)*bpp +: bpp]), whatever `cfg_be_pix` is.
- R4: With only `cfg_be_pix` high and bpp below 8, bytes are consumed from byte 0 upward while the pixels inside each byte go from its most significant bits down; at 8 bpp and above it has no effect.
- R5: In depth codes 0 to 3, `pal_idx` is the pixel field zero-extended to 8 bits and `px_rgb` equals `pal_rgb` unchanged.
- R6: For direct-colour depths, with swap low the field's least significant component is red (`px_rgb[23:16]`) and the most significant is blue (`px_rgb[7:0]`); with swap high they trade places. Green is always `px_rgb[15:8]`.
- R7: In depth code 4, select 1 gives 5551 (components at bits [4:0], [9:5], [14:10], bit 15 ignored); select 3 gives 565 with the low component always blue regardless of swap; selects 0 and 2 give 565 honouring swap. Depth code 6 is 565 honouring swap for every select value.
- R8: 5-bit components widen by appending three zeros, 6-bit by appending two; 12 bpp uses the low 12 bits of a halfword as three 4-bit components, each doubled (x -> {x,x}); in 32-bit mode bytes 0, 1, 2 are low, green and high components and byte 3 is ignored.
- R9: Unless both `cfg_enable` and `cfg_power` are high, `in_ready` and `px_valid` stay low.
- R10: A new word is taken only when no word is held or when the held word's last pixel leaves in the same cycle; while `px_valid` is high and `px_ready` low, `px_rgb` stays constant.
- R11: After reset no word is held: `px_valid` is low and, when active, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Enable bit |
| cfg_power | input | 1 | Power bit; pixels flow only with enable |
| cfg_depth | input | 3 | Depth code |
| cfg_swap_rb | input | 1 | Red/blue component swap |
| cfg_be_byte | input | 1 | Pixel 0 at the word's most significant end |
| cfg_be_pix | input | 1 | Sub-byte pixels from each byte's top bits |
| cfg_fmt16 | input | 2 | External 16-bit format select |
| cfg_cols | input | COL_W | Pixels per line |
| line_bytes | output | COL_W+2 | Bytes per line in memory |
| in_word | input | 32 | Framebuffer word |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Word accepted this cycle when valid |
| pal_idx | output | 8 | Palette lookup index |
| pal_rgb | input | 24 | Palette colour for `pal_idx`, same cycle |
| px_rgb | output | 24 | Pixel colour {R,G,B} |
| px_valid | output | 1 | Pixel available |
| px_ready | input | 1 | Pixel consumer ready |

## Verification
The bench builds the block with the default COL_W of 12, so a column count of 4095 at 32 bits per pixel drives `line_bytes` to its full 14-bit range, and 640 columns exercises every depth code with exact divisions. A combinational palette model in the bench returns a colour derived from the index, which makes any index or ordering error visible on `px_rgb`. Every depth and ordering combination, all four 16-bit select values with both swap settings, stalls with a queued word, back-to-back single-pixel words and the inactive state are all reached with that one build.

// File: rtl/fbu_pkg.sv
// Package: shared constants and helpers for the framebuffer unpacker.
// Assumes a 32-bit fetch word and depth codes 0..7.
package fbu_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 5;

    // Map a depth code to log2 of the bits each pixel occupies in memory.
    function automatic logic [2:0] depth_log2(input logic [2:0] depth);
        case (depth)
            3'd0:    depth_log2 = 3'd0;
            3'd1:    depth_log2 = 3'd1;
            3'd2:    depth_log2 = 3'd2;
            3'd3:    depth_log2 = 3'd3;
            3'd5:    depth_log2 = 3'd5;
            default: depth_log2 = 3'd4;
        endcase
    endfunction

    // Index of the last pixel in a word for a given log2 pixel size.
    function automatic logic [CNT_W-1:0] last_slot(input logic [2:0] lg);
        last_slot = CNT_W'((6'd32 >> lg) - 6'd1);
    endfunction

endpackage

// File: rtl/fbu_word_ctrl.sv
// Word holder and slot counter. Holds one fetched word, steps a pixel
// slot counter on each output transfer, and takes a new word when empty or
// when the last slot leaves. Assumes configuration is stable within a word.
module fbu_word_ctrl
    import fbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [CNT_W-1:0]  slot_last,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              px_ready,
    output logic              px_valid,
    output logic [WORD_W-1:0] word_q,
    output logic [CNT_W-1:0]  slot_q
);

    logic full_q;
    logic fire;
    logic at_last;

    // Handshake decode for both streams.
    always_comb begin
        px_valid = full_q & active;
        fire     = px_valid & px_ready;
        at_last  = (slot_q == slot_last);
        in_ready = active & (~full_q | (fire & at_last));
    end

    // Load, advance and release the held word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            slot_q <= '0;
            word_q <= '0;
        end else if (in_valid && in_ready) begin
            full_q <= 1'b1;
            slot_q <= '0;
            word_q <= in_word;
        end else if (fire && at_last) begin
            full_q <= 1'b0;
            slot_q <= '0;
        end else if (fire) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // A word may arrive while one is held only as its last pixel leaves.
    assert_load_when_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && full_q) |-> (px_ready && slot_q == slot_last));

    // Backpressure freezes the held word and slot.
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && active && !px_ready) |=> ($stable(word_q) && $stable(slot_q)));

endmodule

// File: rtl/fbu_slot_extract.sv
// Slot extractor. Turns a slot number into a bit offset for the chosen
// ordering and returns the pixel field, zero above its width. Assumes the
// slot is below the word's pixel count; the top byte of 32-bit pixels is dropped.
module fbu_slot_extract
    import fbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  slot,
    input  logic [2:0]        lg,
    input  logic              be_byte,
    input  logic              be_pix,
    output logic [23:0]       field
);

    logic [5:0]       bpp;
    logic [4:0]       base;
    logic [4:0]       off;
    logic [WORD_W-1:0] mask;

    // Offset: mirror within the word, within a byte, or take it as is.
    always_comb begin
        bpp  = 6'd1 << lg;
        base = slot << lg;
        mask = WORD_W'((33'd1 << bpp) - 33'd1);
        if (be_byte)
            off = base ^ 5'(6'd32 - bpp);
        else if (be_pix && lg < 3'd3)
            off = base ^ 5'(6'd8 - bpp);
        else
            off = base;
        field = 24'((word >> off) & mask);
    end

    // One-bit pixels never carry bits above bit 0.
    assert_field_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lg == 3'd0) |-> (field[23:1] == '0));

endmodule

// File: rtl/fbu_color_decode.sv
// Colour decoder. Sends indexed fields to the palette port and widens
// direct-colour fields to 8 bits per component, then applies red/blue order.
// Assumes the palette answers combinationally.
module fbu_color_decode (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  depth,
    input  logic        swap_rb,
    input  logic [1:0]  fmt16,
    input  logic [23:0] field,
    input  logic [23:0] pal_rgb,
    output logic [7:0]  pal_idx,
    output logic [23:0] rgb
);

    logic [7:0] c_lo, c_mid, c_hi;
    logic       blue_low;
    logic       indexed;

    // Split the field into low, middle and high components per format.
    always_comb begin
        indexed  = (depth < 3'd4);
        pal_idx  = field[7:0];
        blue_low = swap_rb;
        c_lo     = {field[4:0], 3'b000};
        c_mid    = {field[10:5], 2'b00};
        c_hi     = {field[15:11], 3'b000};
        case (depth)
            3'd4: begin
                if (fmt16 == 2'd1) begin
                    c_mid = {field[9:5], 3'b000};
                    c_hi  = {field[14:10], 3'b000};
                end else if (fmt16 == 2'd3) begin
                    blue_low = 1'b1;
                end
            end
            3'd5: begin
                c_lo  = field[7:0];
                c_mid = field[15:8];
                c_hi  = field[23:16];
            end
            3'd7: begin
                c_lo  = {2{field[3:0]}};
                c_mid = {2{field[7:4]}};
                c_hi  = {2{field[11:8]}};
            end
            default: ;
        endcase
        if (indexed)
            rgb = pal_rgb;
        else if (blue_low)
            rgb = {c_hi, c_mid, c_lo};
        else
            rgb = {c_lo, c_mid, c_hi};
    end

    // 565 output leaves the shifted-in zero bits of every component clear.
    assert_widen_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == 3'd6) |-> (rgb[18:16] == 3'b0 && rgb[9:8] == 2'b0 && rgb[2:0] == 3'b0));

    // 12 bpp components are nibble-doubled.
    assert_nibble_rep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == 3'd7) |-> (rgb[23:20] == rgb[19:16] && rgb[7:4] == rgb[3:0]));

endmodule

// File: rtl/fb_pixel_unpack.sv
// Top: framebuffer pixel format unpacker. Accepts 32-bit words, emits one
// RGB888 pixel per output transfer and reports the line size in bytes.
// Assumes configuration changes only while no word is held.
module fb_pixel_unpack
    import fbu_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_power,
    input  logic [2:0]        cfg_depth,
    input  logic              cfg_swap_rb,
    input  logic              cfg_be_byte,
    input  logic              cfg_be_pix,
    input  logic [1:0]        cfg_fmt16,
    input  logic [COL_W-1:0]  cfg_cols,
    output logic [COL_W+1:0]  line_bytes,
    input  logic [31:0]       in_word,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [7:0]        pal_idx,
    input  logic [23:0]       pal_rgb,
    output logic [23:0]       px_rgb,
    output logic              px_valid,
    input  logic              px_ready
);

    localparam int LB_W = COL_W + 2;

    logic              active;
    logic [2:0]        lg;
    logic [CNT_W-1:0]  slot_last;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  slot_q;
    logic [23:0]       field;

    // Derive the active state and the pixel geometry.
    always_comb begin
        active    = cfg_enable & cfg_power;
        lg        = depth_log2(cfg_depth);
        slot_last = last_slot(lg);
    end

    // Bytes per line from the column count.
    always_comb begin
        case (cfg_depth)
            3'd0:    line_bytes = LB_W'(cfg_cols >> 3);
            3'd1:    line_bytes = LB_W'(cfg_cols >> 2);
            3'd2:    line_bytes = LB_W'(cfg_cols >> 1);
            3'd3:    line_bytes = LB_W'(cfg_cols);
            3'd5:    line_bytes = LB_W'(cfg_cols) << 2;
            default: line_bytes = LB_W'(cfg_cols) << 1;
        endcase
    end

    fbu_word_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .slot_last (slot_last),
        .in_word   (in_word),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .px_ready  (px_ready),
        .px_valid  (px_valid),
        .word_q    (word_q),
        .slot_q    (slot_q)
    );

    fbu_slot_extract u_extract (
        .clk     (clk),
        .rst_n   (rst_n),
        .word    (word_q),
        .slot    (slot_q),
        .lg      (lg),
        .be_byte (cfg_be_byte),
        .be_pix  (cfg_be_pix),
        .field   (field)
    );

    fbu_color_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .depth   (cfg_depth),
        .swap_rb (cfg_swap_rb),
        .fmt16   (cfg_fmt16),
        .field   (field),
        .pal_rgb (pal_rgb),
        .pal_idx (pal_idx),
        .rgb     (px_rgb)
    );

    // Nothing moves on either stream while inactive.
    assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_enable && cfg_power) |-> (!px_valid && !(in_valid && in_ready)));

endmodule

// File: tb/tb_fb_pixel_unpack.sv
`timescale 1ns/1ps
module tb_fb_pixel_unpack;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_enable, cfg_power, cfg_swap_rb, cfg_be_byte, cfg_be_pix;
    logic [2:0]  cfg_depth;
    logic [1:0]  cfg_fmt16;
    logic [11:0] cfg_cols;
    logic [13:0] line_bytes;
    logic [31:0] in_word;
    logic        in_valid, in_ready;
    logic [7:0]  pal_idx;
    logic [23:0] pal_rgb;
    logic [23:0] px_rgb;
    logic        px_valid, px_ready;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    // Palette model: colour derived from index.
    assign pal_rgb = {pal_idx, ~pal_idx, pal_idx ^ 8'h5A};

    fb_pixel_unpack #(.COL_W(12)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(cfg_enable), .cfg_power(cfg_power), .cfg_depth(cfg_depth),
        .cfg_swap_rb(cfg_swap_rb), .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix),
        .cfg_fmt16(cfg_fmt16), .cfg_cols(cfg_cols), .line_bytes(line_bytes),
        .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
        .pal_idx(pal_idx), .pal_rgb(pal_rgb),
        .px_rgb(px_rgb), .px_valid(px_valid), .px_ready(px_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int bpp_of(input logic [2:0] d);
        case (d)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd5: return 32;
            default: return 16;
        endcase
    endfunction

    function automatic logic [31:0] get_field(input logic [31:0] w, input int k);
        int b, off, per;
        b = bpp_of(cfg_depth);
        if (cfg_be_byte) off = 32 - (k + 1) * b;
        else if (cfg_be_pix && b < 8) begin
            per = 8 / b;
            off = (k / per) * 8 + 8 - ((k % per) + 1) * b;
        end else off = k * b;
        return 32'((64'(w) >> off) & ((64'd1 << b) - 64'd1));
    endfunction

    function automatic logic [23:0] exp_px(input logic [31:0] w, input int k);
        logic [31:0] f;
        logic [7:0] lo, mid, hi, i;
        bit sw;
        f  = get_field(w, k);
        sw = cfg_swap_rb;
        if (cfg_depth < 3'd4) begin
            i = f[7:0];
            return {i, ~i, i ^ 8'h5A};
        end
        if (cfg_depth == 3'd5) begin
            lo = f[7:0]; mid = f[15:8]; hi = f[23:16];
        end else if (cfg_depth == 3'd7) begin
            lo = f[3:0] * 8'd17; mid = f[7:4] * 8'd17; hi = f[11:8] * 8'd17;
        end else if (cfg_depth == 3'd4 && cfg_fmt16 == 2'd1) begin
            lo = f[4:0] * 8'd8; mid = f[9:5] * 8'd8; hi = f[14:10] * 8'd8;
        end else begin
            lo = f[4:0] * 8'd8; mid = f[10:5] * 8'd4; hi = f[15:11] * 8'd8;
            if (cfg_depth == 3'd4 && cfg_fmt16 == 2'd3) sw = 1'b1;
        end
        return sw ? {hi, mid, lo} : {lo, mid, hi};
    endfunction

    task automatic set_cfg(input logic [2:0] d, input bit sw, input bit bb,
                           input bit bp, input logic [1:0] fm);
        @(negedge clk);
        cfg_depth = d; cfg_swap_rb = sw; cfg_be_byte = bb; cfg_be_pix = bp; cfg_fmt16 = fm;
    endtask

    // Load one word and drain every pixel, checking each.
    task automatic run_word(input logic [31:0] w, input string req);
        int n;
        n = 32 / bpp_of(cfg_depth);
        @(negedge clk);
        px_ready = 1'b0; in_word = w; in_valid = 1'b1;
        check({req, " in_ready when empty"}, 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            check({req, " px_valid"}, 32'(px_valid), 32'd1);
            check({req, " pixel"}, 32'(px_rgb), 32'(exp_px(w, k)));
            px_ready = 1'b1;
            @(negedge clk);
        end
        px_ready = 1'b0;
        check({req, " empty after last"}, 32'(px_valid), 32'd0);
    endtask

    task automatic t_reset;
        check("R11 px_valid after reset", 32'(px_valid), 32'd0);
        check("R11 in_ready after reset", 32'(in_ready), 32'd1);
    endtask

    task automatic t_line_bytes;
        int exp_lb [8] = '{80, 160, 320, 640, 1280, 2560, 1280, 1280};
        cfg_cols = 12'd640;
        for (int d = 0; d < 8; d++) begin
            @(negedge clk);
            cfg_depth = 3'(d);
            #1 check("R2 line_bytes 640 cols", 32'(line_bytes), 32'(exp_lb[d]));
        end
        @(negedge clk);
        cfg_cols = 12'd4095; cfg_depth = 3'd5;
        #1 check("R2 line_bytes 4095 cols 32-bit", 32'(line_bytes), 32'd16380);
        cfg_depth = 3'd0;
        #1 check("R2 line_bytes 4095 cols 1 bpp", 32'(line_bytes), 32'd511);
    endtask

    task automatic t_indexed;
        set_cfg(3'd0, 0, 0, 0, 2'd0); run_word(32'hA5C3_0F96, "R1 R5 1bpp little");
        set_cfg(3'd3, 0, 0, 0, 2'd0); run_word(32'h8001_FE7F, "R5 8bpp little");
        set_cfg(3'd1, 0, 0, 1, 2'd0); run_word(32'h1B2D_E4C6, "R4 2bpp pixel-swapped");
        set_cfg(3'd2, 1, 1, 1, 2'd0); run_word(32'h0123_ABCD, "R3 4bpp byte order wins");
        set_cfg(3'd3, 0, 0, 1, 2'd0); run_word(32'h1122_3344, "R4 8bpp no effect");
        set_cfg(3'd0, 0, 1, 0, 2'd0); run_word(32'hF00F_1234, "R3 1bpp byte order");
    endtask

    task automatic t_direct;
        set_cfg(3'd4, 0, 0, 0, 2'd1); run_word(32'hFFFF_7C1F, "R7 5551");
        set_cfg(3'd4, 1, 0, 0, 2'd1); run_word(32'h83E0_0421, "R6 R7 5551 swapped");
        set_cfg(3'd4, 0, 0, 0, 2'd3); run_word(32'hF800_07FF, "R7 select3 forces order");
        set_cfg(3'd4, 1, 0, 0, 2'd3); run_word(32'h1234_F81F, "R7 select3 swap ignored");
        set_cfg(3'd4, 1, 0, 0, 2'd0); run_word(32'hABCD_F800, "R6 R7 select0 swapped");
        set_cfg(3'd4, 0, 0, 0, 2'd2); run_word(32'h07E0_001F, "R7 select2");
        set_cfg(3'd6, 1, 0, 0, 2'd1); run_word(32'hF81F_07E0, "R7 depth6 ignores select");
        set_cfg(3'd4, 0, 1, 0, 2'd0); run_word(32'h001F_F800, "R3 16bpp byte order");
        set_cfg(3'd7, 0, 0, 0, 2'd0); run_word(32'hF9A5_0C3E, "R8 12bpp");
        set_cfg(3'd7, 1, 0, 0, 2'd0); run_word(32'h0123_0456, "R6 R8 12bpp swapped");
        set_cfg(3'd5, 0, 0, 0, 2'd0); run_word(32'hDE11_2233, "R8 32bit");
        set_cfg(3'd5, 1, 0, 0, 2'd0); run_word(32'h77AA_BBCC, "R6 R8 32bit swapped");
    endtask

    task automatic t_stall;
        logic [23:0] held;
        set_cfg(3'd4, 0, 0, 0, 2'd0);
        @(negedge clk);
        in_word = 32'h1234_5678; in_valid = 1'b1; px_ready = 1'b0;
        @(negedge clk);
        in_word = 32'h9ABC_DEF0;
        held = px_rgb;
        check("R10 held pixel0", 32'(held), 32'(exp_px(32'h1234_5678, 0)));
        for (int i = 0; i < 3; i++) begin
            check("R10 no load while full", 32'(in_ready), 32'd0);
            @(negedge clk);
            check("R10 stable under stall", 32'(px_rgb), 32'(held));
        end
        px_ready = 1'b1;
        @(negedge clk);
        check("R10 pixel1", 32'(px_rgb), 32'(exp_px(32'h1234_5678, 1)));
        check("R10 load on last pixel", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 next word pixel0", 32'(px_rgb), 32'(exp_px(32'h9ABC_DEF0, 0)));
        @(negedge clk);
        check("R10 next word pixel1", 32'(px_rgb), 32'(exp_px(32'h9ABC_DEF0, 1)));
        @(negedge clk);
        px_ready = 1'b0;
        check("R10 drained", 32'(px_valid), 32'd0);
    endtask

    task automatic t_stream32;
        set_cfg(3'd5, 0, 0, 0, 2'd0);
        @(negedge clk);
        px_ready = 1'b1; in_valid = 1'b1; in_word = 32'h0011_2233;
        @(negedge clk);
        in_word = 32'h0044_5566;
        check("R10 back-to-back first", 32'(px_rgb), 32'(exp_px(32'h0011_2233, 0)));
        check("R10 back-to-back ready", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 back-to-back second", 32'(px_rgb), 32'(exp_px(32'h0044_5566, 0)));
        @(negedge clk);
        px_ready = 1'b0;
        check("R10 stream drained", 32'(px_valid), 32'd0);
    endtask

    task automatic t_inactive;
        set_cfg(3'd3, 0, 0, 0, 2'd0);
        @(negedge clk);
        cfg_power = 1'b0; in_valid = 1'b1; in_word = 32'hCAFE_F00D; px_ready = 1'b1;
        @(negedge clk);
        check("R9 power off in_ready", 32'(in_ready), 32'd0);
        check("R9 power off px_valid", 32'(px_valid), 32'd0);
        cfg_power = 1'b1; cfg_enable = 1'b0;
        @(negedge clk);
        check("R9 enable off in_ready", 32'(in_ready), 32'd0);
        check("R9 enable off px_valid", 32'(px_valid), 32'd0);
        in_valid = 1'b0; px_ready = 1'b0;
        cfg_enable = 1'b1;
        @(negedge clk);
        check("R9 nothing held after off", 32'(px_valid), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_enable = 1'b1; cfg_power = 1'b1; cfg_depth = 3'd0; cfg_swap_rb = 1'b0;
        cfg_be_byte = 1'b0; cfg_be_pix = 1'b0; cfg_fmt16 = 2'd0; cfg_cols = 12'd640;
        in_word = '0; in_valid = 1'b0; px_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_line_bytes();
        t_indexed();
        t_direct();
        t_stall();
        t_stream32();
        t_inactive();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule